// File: doc/BRIEF.md
# Indirect Load/Store Address Sequencer

This unit executes one group of 16-bit indirect memory-access instructions. A single issue pulse hands it the first instruction word. It reads a 32-bit base address from one of four pointer pairs in the register file. It may add a signed 16-bit offset to that base. The offset comes either from a general-purpose register or from a second instruction word, which the unit requests on a fetch handshake. The unit then moves one or more words between memory and consecutive registers. When the instruction asks for it, the pointer pair is written back with base plus offset, either before the first access or after the last one.

The unit has three external ports. The register file has one combinational read port and one write port, with registers addressed as {bank, index}: bank 0 holds the eight general registers and bank 1 holds the eight pointer halves. The memory port is a request/acknowledge port. The third is the fetch handshake for the offset word. `busy` is high while an instruction is in flight, and `done` is high for the last cycle of the instruction.

Top module: `ind_ldst_seq`

## Requirements
- R1: Instruction bit 12 selects a load (0) or a store (1). Bit 11 selects the general bank (0) or the pointer bank (1) for the data register, and bits 10..8 give its index.
- R2: Bits 1..0 select the base pair: 00 program counter, 01 stack pointer, 10 frame pointer, 11 base pointer. Pair p is made of pointer-bank register 2p, which holds address bits 15..0, and register 2p+1, which holds bits 31..16.
- R3: With bit 4 = 0 the pointer pair is never written. The first access goes to the base when bit 3 = 0 and to base plus offset when bit 3 = 1.
- R4: With bit 4 = 1 and bit 3 = 0, the first access goes to the base, and the pair is written with base plus offset after the last access.
- R5: With bit 4 = 1 and bit 3 = 1, the pair is written with base plus offset before any access, and the first access uses that updated value.
- R6: The offset is sign-extended from 16 bits. When bit 2 = 0 it is read from the general register named by bits 7..5. When bit 2 = 1 it is taken from `fetch_word` through the `fetch_req`/`fetch_ack` handshake.
- R7: An encoding with bits 4, 3 and 2 equal to 0, 0 and 1 fetches the offset word but ignores it. It gives the same result as the form without an offset and holds `busy` exactly one cycle longer when the word arrives in the cycle it is requested.
- R8: `word_cnt` = k, sampled at issue, moves k+1 words. Word i uses the first address plus i and the data register at index (index + i) mod 8 in the same bank. The instruction holds `busy` for 3 + 2·(bit 4) + (bit 2, or else 1 when bit 4 or bit 3 is set) + (k+1)·(2 + L) cycles, where L is the number of wait cycles before `mem_ack`.
- R9: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay stable. No register write occurs in a cycle with a memory or fetch request.
- R10: `done` is high for exactly one cycle, the last busy cycle. `start` is ignored while `busy` is high.
- R11: All address arithmetic wraps modulo 2^32.
- R12: A `start` whose bits 15..13 are not 011 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse, sampled while idle |
| instr | input | 16 | First instruction word |
| word_cnt | input | CNT_W | Number of extra words to transfer |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Last cycle of the instruction |
| fetch_req | output | 1 | Request for the offset word |
| fetch_ack | input | 1 | Offset word valid |
| fetch_word | input | 16 | Offset word |
| rf_rd_sel | output | 4 | Register read select {bank, index} |
| rf_rd_data | input | 16 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_wr_sel | output | 4 | Register write select {bank, index} |
| rf_wr_data | output | 16 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with acknowledge |

## Verification
Most internal faults show up on the memory port during the same instruction. A wrong latched base, offset or word index puts a wrong `mem_addr` on the very first or the next access. A wrong phase order shows as a pointer write that comes before the access in a post-increment, or after it in a pre-increment, and this appears in the register contents once `done` is seen. A miscounted burst changes both the number of accesses and the busy length. The bench therefore checks every acknowledged address in order, the final register and memory image, and the exact busy-cycle count.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int W       = 16;
    localparam int ADDR_W  = 2 * W;
    localparam int REG_W   = 3;
    localparam int SEL_W   = REG_W + 1;
    localparam logic [2:0] GROUP_OP = 3'b011;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_ROFF, S_BLO, S_BHI,
        S_PWLO, S_PWHI, S_SRC, S_MEM, S_LDWB, S_DONE
    } phase_e;

    typedef struct packed {
        logic             store;
        logic             mp_bank;
        logic [REG_W-1:0] reg_idx;
        logic [REG_W-1:0] off_reg;
        logic             upd;
        logic             pre;
        logic             imm;
        logic [1:0]       pair;
    } dec_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [W-1:0] word,
    output dec_t         dec,
    output logic         hit
);
    always_comb begin
        dec.store   = word[12];
        dec.mp_bank = word[11];
        dec.reg_idx = word[10:8];
        dec.off_reg = word[7:5];
        dec.upd     = word[4];
        dec.pre     = word[3];
        dec.imm     = word[2];
        dec.pair    = word[1:0];
        hit         = (word[15:13] == GROUP_OP);
    end
endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
    import ldst_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [W-1:0]      off,
    input  logic              pre,
    output logic [ADDR_W-1:0] upd,
    output logic [ADDR_W-1:0] first
);
    logic [ADDR_W-1:0] off_sx;
    always_comb begin
        off_sx = {{(ADDR_W-W){off[W-1]}}, off};
        upd    = base + off_sx;
        first  = pre ? upd : base;
    end
endmodule

// File: rtl/ind_ldst_seq.sv
module ind_ldst_seq
    import ldst_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic              busy,
    output logic              done,
    output logic              fetch_req,
    input  logic              fetch_ack,
    input  logic [15:0]       fetch_word,
    output logic [3:0]        rf_rd_sel,
    input  logic [15:0]       rf_rd_data,
    output logic              rf_we,
    output logic [3:0]        rf_wr_sel,
    output logic [15:0]       rf_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata
);
    typedef struct packed {
        phase_e            ph;
        dec_t              d;
        logic [W-1:0]      off;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  last;
        logic [CNT_W-1:0]  idx;
        logic [W-1:0]      data;
        logic              accessed;
    } st_t;

    st_t q, n;

    dec_t              dec_in;
    logic              op_hit;
    logic [ADDR_W-1:0] upd_ptr, first_addr;

    ldst_decode u_dec (.word(instr), .dec(dec_in), .hit(op_hit));

    ldst_addr u_addr (
        .base (q.base),
        .off  (q.off),
        .pre  (q.d.pre),
        .upd  (upd_ptr),
        .first(first_addr)
    );

    logic [REG_W-1:0] data_reg;
    logic             last_word;
    phase_e           word_ph, after_ph;

    always_comb begin
        n          = q;
        data_reg   = q.d.reg_idx + REG_W'(q.idx);
        last_word  = (q.idx == q.last);
        word_ph    = q.d.store ? S_SRC : S_MEM;
        after_ph   = last_word ? ((q.d.upd && !q.d.pre) ? S_PWLO : S_DONE) : word_ph;

        busy       = (q.ph != S_IDLE);
        done       = (q.ph == S_DONE);
        fetch_req  = 1'b0;
        rf_rd_sel  = '0;
        rf_we      = 1'b0;
        rf_wr_sel  = '0;
        rf_wr_data = '0;
        mem_req    = (q.ph == S_MEM);
        mem_we     = (q.ph == S_MEM) && q.d.store;
        mem_addr   = first_addr + ADDR_W'(q.idx);
        mem_wdata  = q.data;

        unique case (q.ph)
            S_IDLE: begin
                if (start && op_hit) begin
                    n.d        = dec_in;
                    n.last     = word_cnt;
                    n.idx      = '0;
                    n.off      = '0;
                    n.accessed = 1'b0;
                    if (dec_in.imm)                     n.ph = S_FETCH;
                    else if (dec_in.upd || dec_in.pre)  n.ph = S_ROFF;
                    else                                n.ph = S_BLO;
                end
            end
            S_FETCH: begin
                fetch_req = 1'b1;
                if (fetch_ack) begin
                    n.off = fetch_word;
                    n.ph  = S_BLO;
                end
            end
            S_ROFF: begin
                rf_rd_sel = {1'b0, q.d.off_reg};
                n.off     = rf_rd_data;
                n.ph      = S_BLO;
            end
            S_BLO: begin
                rf_rd_sel        = {1'b1, q.d.pair, 1'b0};
                n.base[W-1:0]    = rf_rd_data;
                n.ph             = S_BHI;
            end
            S_BHI: begin
                rf_rd_sel          = {1'b1, q.d.pair, 1'b1};
                n.base[ADDR_W-1:W] = rf_rd_data;
                n.ph               = (q.d.upd && q.d.pre) ? S_PWLO : word_ph;
            end
            S_PWLO: begin
                rf_we      = 1'b1;
                rf_wr_sel  = {1'b1, q.d.pair, 1'b0};
                rf_wr_data = upd_ptr[W-1:0];
                n.ph       = S_PWHI;
            end
            S_PWHI: begin
                rf_we      = 1'b1;
                rf_wr_sel  = {1'b1, q.d.pair, 1'b1};
                rf_wr_data = upd_ptr[ADDR_W-1:W];
                n.ph       = q.accessed ? S_DONE : word_ph;
            end
            S_SRC: begin
                rf_rd_sel = {q.d.mp_bank, data_reg};
                n.data    = rf_rd_data;
                n.ph      = S_MEM;
            end
            S_MEM: begin
                if (mem_ack) begin
                    if (q.d.store) begin
                        n.ph = after_ph;
                        if (last_word) n.accessed = 1'b1;
                        else           n.idx = q.idx + 1'b1;
                    end else begin
                        n.data = mem_rdata;
                        n.ph   = S_LDWB;
                    end
                end
            end
            S_LDWB: begin
                rf_we      = 1'b1;
                rf_wr_sel  = {q.d.mp_bank, data_reg};
                rf_wr_data = q.data;
                n.ph       = after_ph;
                if (last_word) n.accessed = 1'b1;
                else           n.idx = q.idx + 1'b1;
            end
            S_DONE:  n.ph = S_IDLE;
            default: n.ph = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end
endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        fetch_req,
    input logic        rf_we,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ack
);
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!mem_req && !fetch_req));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_before_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_stays_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind ind_ldst_seq ldst_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fetch_req(fetch_req),
    .rf_we(rf_we), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_ind_ldst_seq.sv
module test_ind_ldst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  word_cnt = '0;
    logic        busy, done, fetch_req, fetch_ack;
    logic [15:0] fetch_word;
    logic [3:0]  rf_rd_sel, rf_wr_sel;
    logic [15:0] rf_rd_data, rf_wr_data;
    logic        rf_we, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #10 clk = ~clk;

    logic [15:0] gpr [8];
    logic [15:0] mp  [8];
    logic [15:0] mem [256];
    logic [15:0] e_gpr [8];
    logic [15:0] e_mp  [8];
    logic [15:0] e_mem [256];
    logic [31:0] e_addr [8];
    int          e_n;
    int          lat;
    int          acc_k;
    int          wcnt;
    logic [15:0] imm_word;
    string       cur_tag;
    logic [31:0] prev_addr;
    logic        prev_wait;
    int          errors = 0;
    int          checks = 0;
    int          cyc_all = 0;

    assign fetch_ack  = fetch_req;
    assign fetch_word = imm_word;
    assign rf_rd_data = rf_rd_sel[3] ? mp[rf_rd_sel[2:0]] : gpr[rf_rd_sel[2:0]];

    ind_ldst_seq #(.CNT_W(3)) i_ind_ldst_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .word_cnt(word_cnt),
        .busy(busy), .done(done), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
        .fetch_word(fetch_word), .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // memory, register-file and fetch models, all acting between clock edges
    always @(negedge clk) begin
        if (rf_we) begin
            if (rf_wr_sel[3]) mp[rf_wr_sel[2:0]] = rf_wr_data;
            else              gpr[rf_wr_sel[2:0]] = rf_wr_data;
        end
        if (mem_req && !mem_ack && prev_wait)
            chk(mem_addr == prev_addr, "R9", "address held while waiting", 64'(mem_addr), 64'(prev_addr));
        prev_wait = mem_req && !mem_ack;
        prev_addr = mem_addr;
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end else if (mem_req) begin
            if (wcnt == lat) begin
                mem_ack = 1'b1;
                chk(acc_k < 8 && mem_addr == e_addr[acc_k & 7], cur_tag, "access address",
                    64'(mem_addr), 64'(e_addr[acc_k & 7]));
                acc_k++;
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:0]];
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all == 150000) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog expired: actual %0d expected below %0d", cyc_all, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic init_state();
        for (int i = 0; i < 8; i++) gpr[i] = 16'h1100 + 16'(i * 16'h0111);
        gpr[2] = 16'hFFF8;
        gpr[6] = 16'h0003;
        mp[0] = 16'h0010; mp[1] = 16'h0000;
        mp[2] = 16'hFFFE; mp[3] = 16'hFFFF;
        mp[4] = 16'h0080; mp[5] = 16'h1234;
        mp[6] = 16'h0005; mp[7] = 16'h0000;
        for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i * 7);
    endtask

    // reference: offset, base, pre write, words in order, post write
    task automatic model(input logic [15:0] ins, input logic [2:0] cnt, input logic [15:0] immw,
                         input int l, output int cyc);
        logic st, bk, up, pr, im;
        logic [2:0] r, ri;
        logic [1:0] p;
        logic [15:0] off;
        logic [31:0] base, nb, a0, a;
        st = ins[12]; bk = ins[11]; r = ins[10:8]; up = ins[4]; pr = ins[3]; im = ins[2]; p = ins[1:0];
        for (int i = 0; i < 8; i++) begin e_gpr[i] = gpr[i]; e_mp[i] = mp[i]; end
        for (int i = 0; i < 256; i++) e_mem[i] = mem[i];
        off  = im ? immw : ((up || pr) ? e_gpr[ins[7:5]] : 16'h0);
        base = {e_mp[{p, 1'b1}], e_mp[{p, 1'b0}]};
        nb   = base + {{16{off[15]}}, off};
        a0   = pr ? nb : base;
        if (up && pr) begin e_mp[{p, 1'b0}] = nb[15:0]; e_mp[{p, 1'b1}] = nb[31:16]; end
        for (int i = 0; i <= int'(cnt); i++) begin
            a  = a0 + 32'(i);
            ri = r + 3'(i);
            e_addr[i] = a;
            if (st) e_mem[a[7:0]] = bk ? e_mp[ri] : e_gpr[ri];
            else if (bk) e_mp[ri] = e_mem[a[7:0]];
            else e_gpr[ri] = e_mem[a[7:0]];
        end
        if (up && !pr) begin e_mp[{p, 1'b0}] = nb[15:0]; e_mp[{p, 1'b1}] = nb[31:16]; end
        e_n = int'(cnt) + 1;
        cyc = int'(im) + ((!im && (up || pr)) ? 1 : 0) + 2 + 2 * int'(up) + e_n * (2 + l) + 1;
    endtask

    task automatic run_one(input logic [15:0] ins, input logic [2:0] cnt, input logic [15:0] immw,
                           input int l, input bit poke, input string tag, output int cyc);
        int exp_cyc, n, bad;
        bit seen;
        init_state();
        model(ins, cnt, immw, l, exp_cyc);
        lat = l; acc_k = 0; cur_tag = tag; imm_word = immw;
        @(negedge clk);
        start = 1'b1; instr = ins; word_cnt = cnt;
        @(negedge clk);
        start = 1'b0;
        n = 0; seen = 1'b0;
        for (int k = 0; k < 200 && !seen; k++) begin
            if (busy) n++;
            if (poke && k == 2) begin
                start = 1'b1; instr = 16'h7F1F; word_cnt = 3'd7;
            end else begin
                start = 1'b0;
            end
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        start = 1'b0;
        chk(seen, tag, "done reached", 64'(seen), 64'd1);
        @(negedge clk);
        chk(!done && !busy, "R10", "done lasts one cycle", 64'({done, busy}), 64'd0);
        chk(n == exp_cyc, tag, "busy cycles", 64'(n), 64'(exp_cyc));
        chk(acc_k == e_n, tag, "access count", 64'(acc_k), 64'(e_n));
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (gpr[i] !== e_gpr[i]) bad++;
            if (mp[i] !== e_mp[i]) bad++;
        end
        for (int i = 0; i < 256; i++) if (mem[i] !== e_mem[i]) bad++;
        chk(bad == 0, tag, "register and memory image mismatches", 64'(bad), 64'd0);
        cyc = n;
    endtask

    initial begin
        int c0, c1, bad;
        string tg;
        logic [15:0] ins;
        lat = 0; acc_k = 0; wcnt = 0; imm_word = '0; prev_wait = 1'b0; prev_addr = '0;
        cur_tag = "R3";
        init_state();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we && !fetch_req, "R10", "reset outputs",
            64'({busy, done, mem_req, rf_we, fetch_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: foreign opcodes do not start the unit
        start = 1'b1; instr = 16'h1E1D; word_cnt = 3'd2;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R12", "foreign opcode busy", 64'(busy), 64'd0);
        start = 1'b1; instr = 16'hE71D;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R12", "foreign opcode idle", 64'({busy, done}), 64'd0);

        // R7: redundant offset-word form costs one cycle
        run_one(16'h6301, 3'd0, 16'h0000, 0, 1'b0, "R7", c0);
        run_one(16'h6305, 3'd0, 16'h1234, 0, 1'b0, "R7", c1);
        chk(c1 == c0 + 1, "R7", "extra cycle", 64'(c1), 64'(c0 + 1));

        // directed cases
        run_one(16'h7A02, 3'd0, 16'h0000, 0, 1'b0, "R1", c0);   // store pointer reg 2 via FP
        run_one(16'h6800, 3'd1, 16'h0000, 1, 1'b0, "R2", c0);   // load into pointer regs 0,1 via PC
        run_one(16'h631F, 3'd2, 16'hFFF8, 0, 1'b0, "R6", c0);   // negative word offset, pre
        run_one(16'h621D, 3'd2, 16'h0001, 2, 1'b0, "R11", c0);  // SP 0xFFFFFFFE pre +1 wraps
        run_one(16'h6156, 3'd1, 16'h0000, 1, 1'b1, "R10", c0);  // start poked mid-run

        // sweep: direction, bank, mode, offset source, pair, count
        for (int ld = 0; ld < 2; ld++)
        for (int bk = 0; bk < 2; bk++)
        for (int m = 0; m < 4; m++)
        for (int im = 0; im < 2; im++)
        for (int p = 0; p < 4; p++)
        for (int cn = 0; cn < 3; cn++) begin
            ins = {3'b011, 1'(ld), 1'(bk), 3'(p * 2 + cn + 5),
                   (p[0] ? 3'd2 : 3'd6), 1'(m >> 1), 1'(m), 1'(im), 2'(p)};
            if (cn > 0) tg = "R8";
            else if (m[1]) tg = m[0] ? "R5" : "R4";
            else tg = "R3";
            run_one(ins, 3'(cn), (p[1] ? 16'h8000 : 16'h0005), (p + cn + m) % 3, 1'b0, tg, c0);
        end

        bad = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule